// File: doc/BRIEF.md
# Grouped interrupt summary aggregator

This block condenses the pending state of a large set of pins into a short summary vector and a single parent interrupt line. A pin counts as pending when either its interrupt status or its wake status is high. The pins are taken four at a time, so each summary bit stands for one group of four consecutive pins. With the default of 184 pins that gives 46 summary bits. Software reads them as two 32-bit words: the low word holds groups 0 to 31 and the high word holds groups 32 to 45.

The parent line is sticky. It rises once any summary bit is set, and it stays high until software writes the end-of-interrupt bit, even if every pin has been cleared in the meantime. An end-of-interrupt write pulls the line low for exactly one cycle. After that cycle the line follows the summary again, so it comes straight back if anything is still pending.

Top module: `irq_group_summary`

## Requirements
- R1: Summary bit k is high when any of pins 4k, 4k+1, 4k+2 and 4k+3 is pending, and low when none of them is pending. It follows the pins with one cycle of latency.
- R2: A pin is pending when its interrupt status input is high, when its wake status input is high, or when both are high.
- R3: Register address 0 returns summary bits 31..0. Address 1 returns summary bits 45..32 in data bits 13..0, and data bits 31..14 of that address read as 0. Read data is registered and appears one cycle after the address.
- R4: Address 2 is the master control register, and it always reads as 0, including right after the end-of-interrupt bit has been written as 1. Address 3 also reads as 0.
- R5: Reset is synchronous and active-high. During reset, and on the first cycle after it, the parent line is low and the read data is 0.
- R6: Once a summary bit becomes set, the parent line goes high one cycle later. It then stays high, even after all pins clear, until an end-of-interrupt write arrives.
- R7: An end-of-interrupt write sets bit 0 of the write data at address 2. It forces the parent line low on the next cycle. On the cycle after that, the line is high again if any summary bit is set.
- R8: When no summary bit is set and the line is low, the line stays low, including after an end-of-interrupt write.
- R9: The following writes change neither the summary words nor the parent line:
  - writes to addresses 0 or 1;
  - writes to address 2 with bit 0 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_int_sts | input | NUM_PINS | Per-pin interrupt status |
| pin_wake_sts | input | NUM_PINS | Per-pin wake status |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 low word, 1 high word, 2 master, 3 unused) |
| reg_wdata | input | WORD_W | Write data; bit 0 at address 2 is end-of-interrupt |
| reg_rdata | output | WORD_W | Registered read data for reg_addr |
| parent_irq | output | 1 | Sticky upstream interrupt line |

## Verification
The grouping is driven with several pin patterns, and each one separates a different fault:
- A single pin at the low edge shows the group index is computed correctly.
- A wake-only pin next to mixed pins in the same group shows that the two status sources are ORed and that a group collapses to one bit.
- Pins at the top of the vector show that the high word starts at group 32 and that its unused upper bits read as zero.
- All pins set, and then an alternating group pattern, show that no group leaks into a neighbouring group.

The parent line is checked in three situations:
- with pending pins cleared before the end-of-interrupt write, to show the line is sticky;
- with pins still pending at the end-of-interrupt write, to show the one-cycle gap and the re-assertion;
- with writes that must have no effect, to show that only the end-of-interrupt bit releases the line.

// File: rtl/igs_pkg.sv
package igs_pkg;
  typedef enum logic [1:0] {
    ADR_SUM_LO = 2'd0,
    ADR_SUM_HI = 2'd1,
    ADR_MASTER = 2'd2,
    ADR_RSVD   = 2'd3
  } igs_addr_e;

  localparam int EOI_BIT = 0;
endpackage

// File: rtl/igs_group_or.sv
module igs_group_or #(
  parameter int NUM_PINS = 184,
  parameter int GROUP    = 4,
  localparam int NUM_GROUPS = (NUM_PINS + GROUP - 1) / GROUP,
  localparam int PAD_W      = NUM_GROUPS * GROUP
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PINS-1:0]   int_sts,
  input  logic [NUM_PINS-1:0]   wake_sts,
  output logic [NUM_GROUPS-1:0] sum_q
);
  logic [PAD_W-1:0]      pend_pad;
  logic [NUM_GROUPS-1:0] sum_d;

  always_comb begin
    pend_pad = '0;
    pend_pad[NUM_PINS-1:0] = int_sts | wake_sts;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign sum_d[g] = |pend_pad[g*GROUP +: GROUP];
  end

  always_ff @(posedge clk) begin
    if (rst) sum_q <= '0;
    else     sum_q <= sum_d;
  end

  AST_GROUP_IDLE: assert property (@(posedge clk) disable iff (rst)
    ((int_sts | wake_sts) == '0) |=> (sum_q == '0)); // R1
  AST_WAKE_ONLY_HITS: assert property (@(posedge clk) disable iff (rst)
    (wake_sts[0] && !int_sts[0]) |=> sum_q[0]); // R2
endmodule

// File: rtl/igs_readback.sv
module igs_readback
  import igs_pkg::*;
#(
  parameter int NUM_GROUPS = 46,
  parameter int WORD_W     = 32,
  localparam int EXT_W     = 2 * WORD_W,
  localparam int HI_USED   = NUM_GROUPS - WORD_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            addr,
  input  logic [NUM_GROUPS-1:0] sum,
  output logic [WORD_W-1:0]     rdata_q
);
  logic [EXT_W-1:0]  sum_ext;
  logic [WORD_W-1:0] rdata_d;

  always_comb begin
    sum_ext = '0;
    sum_ext[NUM_GROUPS-1:0] = sum;
  end

  always_comb begin
    case (igs_addr_e'(addr))
      ADR_SUM_LO: rdata_d = sum_ext[WORD_W-1:0];
      ADR_SUM_HI: rdata_d = sum_ext[EXT_W-1:WORD_W];
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rdata_d;
  end

  AST_MASTER_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (addr == ADR_MASTER) |=> (rdata_q == '0)); // R4
  AST_HI_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (addr == ADR_SUM_HI) |=> (rdata_q[WORD_W-1:HI_USED] == '0)); // R3
endmodule

// File: rtl/igs_parent_irq.sv
module igs_parent_irq (
  input  logic clk,
  input  logic rst,
  input  logic any_sum,
  input  logic eoi,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (rst)      irq_q <= 1'b0;
    else if (eoi) irq_q <= 1'b0;
    else          irq_q <= irq_q | any_sum;
  end

  AST_EOI_DROPS: assert property (@(posedge clk) disable iff (rst)
    eoi |=> !irq_q); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !eoi) |=> irq_q); // R6
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!irq_q && !any_sum) |=> !irq_q); // R8
endmodule

// File: rtl/irq_group_summary.sv
module irq_group_summary
  import igs_pkg::*;
#(
  parameter int NUM_PINS = 184,
  parameter int GROUP    = 4,
  parameter int WORD_W   = 32,
  localparam int NUM_GROUPS = (NUM_PINS + GROUP - 1) / GROUP
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_int_sts,
  input  logic [NUM_PINS-1:0] pin_wake_sts,
  input  logic                reg_wr,
  input  logic [1:0]          reg_addr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  output logic                parent_irq
);
  logic [NUM_GROUPS-1:0] sum_q;
  logic                  eoi;

  assign eoi = reg_wr && (reg_addr == ADR_MASTER) && reg_wdata[EOI_BIT];

  igs_group_or #(.NUM_PINS(NUM_PINS), .GROUP(GROUP)) u_group (
    .clk      (clk),
    .rst      (rst),
    .int_sts  (pin_int_sts),
    .wake_sts (pin_wake_sts),
    .sum_q    (sum_q)
  );

  igs_readback #(.NUM_GROUPS(NUM_GROUPS), .WORD_W(WORD_W)) u_rdbk (
    .clk     (clk),
    .rst     (rst),
    .addr    (reg_addr),
    .sum     (sum_q),
    .rdata_q (reg_rdata)
  );

  igs_parent_irq u_irq (
    .clk     (clk),
    .rst     (rst),
    .any_sum (|sum_q),
    .eoi     (eoi),
    .irq_q   (parent_irq)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!parent_irq && reg_rdata == '0)); // R5
endmodule

// File: tb/test_irq_group_summary.sv
module test_irq_group_summary;
  localparam int NP = 184;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NP-1:0]   pin_int_sts = '0;
  logic [NP-1:0]   pin_wake_sts = '0;
  logic            reg_wr = 1'b0;
  logic [1:0]      reg_addr = 2'd0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            parent_irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  irq_group_summary i_irq_group_summary (
    .clk(clk), .rst(rst), .pin_int_sts(pin_int_sts), .pin_wake_sts(pin_wake_sts),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .parent_irq(parent_irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a);
    reg_addr = a;
    step(1);
  endtask

  task automatic wr_master(input logic [31:0] wd);
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = wd;
    step(1);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic quiesce();
    pin_int_sts = '0; pin_wake_sts = '0;
    step(2);
    wr_master(32'h1);
    step(1);
    chk("R8 idle after clear", {31'd0, parent_irq}, 32'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1; reg_addr = 2'd0;
    step(3);
    chk("R5 irq in reset", {31'd0, parent_irq}, 32'd0);
    chk("R5 rdata in reset", reg_rdata, 32'd0);
    rst = 1'b0;
    step(1);
    chk("R5 irq after reset", {31'd0, parent_irq}, 32'd0);
  endtask

  task automatic t_single();
    pin_int_sts[0] = 1'b1;
    step(2);
    chk("R6 irq rises", {31'd0, parent_irq}, 32'd1);
    rd(2'd0); chk("R1 pin0 low word", reg_rdata, 32'h1);
    rd(2'd1); chk("R1 pin0 high word", reg_rdata, 32'h0);
    quiesce();
  endtask

  task automatic t_wake();
    pin_wake_sts[7] = 1'b1;
    step(2);
    rd(2'd0); chk("R2 wake pin7", reg_rdata, 32'h2);
    pin_wake_sts[5] = 1'b1; pin_int_sts[6] = 1'b1; pin_int_sts[7] = 1'b1;
    step(2);
    rd(2'd0); chk("R2 mixed same group", reg_rdata, 32'h2);
    quiesce();
  endtask

  task automatic t_high();
    pin_int_sts[131] = 1'b1; pin_wake_sts[183] = 1'b1;
    step(2);
    rd(2'd1); chk("R3 high word groups 32,45", reg_rdata, 32'h2001);
    rd(2'd0); chk("R3 low word empty", reg_rdata, 32'h0);
    quiesce();
  endtask

  task automatic t_all();
    pin_int_sts = '1;
    step(2);
    rd(2'd0); chk("R3 all low word", reg_rdata, 32'hFFFF_FFFF);
    rd(2'd1); chk("R3 all high word padded", reg_rdata, 32'h0000_3FFF);
    quiesce();
  endtask

  task automatic t_pattern();
    for (int g = 0; g < 46; g += 2) pin_int_sts[g*4 + (g % 4)] = 1'b1;
    step(2);
    rd(2'd0); chk("R1 alternating low", reg_rdata, 32'h5555_5555);
    rd(2'd1); chk("R1 alternating high", reg_rdata, 32'h0000_1555);
    quiesce();
  endtask

  task automatic t_sticky();
    pin_int_sts[10] = 1'b1;
    step(2);
    chk("R6 irq set", {31'd0, parent_irq}, 32'd1);
    pin_int_sts = '0;
    step(4);
    chk("R6 irq held after clear", {31'd0, parent_irq}, 32'd1);
    rd(2'd0); chk("R1 summary follows pins", reg_rdata, 32'h0);
    wr_master(32'h1);
    chk("R7 eoi drops line", {31'd0, parent_irq}, 32'd0);
    step(1);
    chk("R8 stays low nothing pending", {31'd0, parent_irq}, 32'd0);
    step(3);
    chk("R8 still low", {31'd0, parent_irq}, 32'd0);
  endtask

  task automatic t_eoi_pending();
    pin_wake_sts[50] = 1'b1;
    step(2);
    wr_master(32'h1);
    chk("R7 one-cycle gap", {31'd0, parent_irq}, 32'd0);
    step(1);
    chk("R7 reasserts while pending", {31'd0, parent_irq}, 32'd1);
    quiesce();
  endtask

  task automatic t_writes();
    pin_int_sts[20] = 1'b1;
    step(2);
    reg_wr = 1'b1; reg_wdata = 32'hFFFF_FFFF;
    reg_addr = 2'd0; step(1);
    reg_addr = 2'd1; step(1);
    reg_wr = 1'b0; reg_wdata = '0;
    rd(2'd0); chk("R9 low word unchanged", reg_rdata, 32'h20);
    rd(2'd1); chk("R9 high word unchanged", reg_rdata, 32'h0);
    wr_master(32'hFFFF_FFFE);
    chk("R9 master without eoi keeps irq", {31'd0, parent_irq}, 32'd1);
    wr_master(32'h1);
    rd(2'd2); chk("R4 master reads zero", reg_rdata, 32'h0);
    rd(2'd3); chk("R4 unused address zero", reg_rdata, 32'h0);
    quiesce();
  endtask

  initial begin
    t_reset();
    t_single();
    t_wake();
    t_high();
    t_all();
    t_pattern();
    t_sticky();
    t_eoi_pending();
    t_writes();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired got running exp finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule